// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block reconfigures an external phase-locked loop without ever letting an unlocked clock escape. A one-cycle start request carries a precomputed multiplier word. The sequencer first reads the PLL control register. It then writes that register back with the PLL powered down and with bypass, both direct paths and the output enable all cleared. Next it loads the multiplier register and writes the divide-by-one word to the pre/post-divider register. A further control write powers the PLL up.

After power-up the sequencer waits a fixed interval, given in clock cycles, and samples the status register. It does this up to a bounded number of times. When a sample shows lock, one last control write turns the clock output on and a one-cycle done pulse ends the run. If no sample shows lock, the output stays off and a one-cycle error pulse ends the run. Every register access goes through a valid/ready write port or a matching valid/ready read port, and the two are never active together.

States: IDLE, RD_CTRL (read control), WR_PD (power-down write), WR_MUL (multiplier write), WR_DIV (divider write), WR_PU (power-up write), WAIT (interval timer), RD_STAT (status poll), WR_EN (output-enable write), DONE, FAIL. The transitions are:
- IDLE to RD_CTRL on start.
- RD_CTRL to WR_PD, WR_PD to WR_MUL, WR_MUL to WR_DIV, WR_DIV to WR_PU, and WR_PU to WAIT, each when its port is ready.
- WAIT to RD_STAT when the timer expires.
- RD_STAT to WR_EN when lock is seen, to FAIL on the last unlocked poll, and otherwise back to WAIT.
- WR_EN to DONE when ready.
- DONE and FAIL return to IDLE after one cycle.

Top module: `pll_reprog_seq`

## Requirements
- R1: A start pulse in IDLE makes busy high on the next cycle, and the first bus operation is a read of the control address (default 0x04).
- R2: The first write goes to the control address with the value read back, with bit 0 (power-down) set and bits 1 to 4 (bypass, direct-in, direct-out, output enable) cleared. All other bits are kept.
- R3: The second write puts the start multiplier word at the multiplier address (default 0x08). The third write puts 0x00302062 at the divider address (default 0x0C).
- R4: The fourth write goes to the control address with bits 0 to 4 all cleared and all other bits kept.
- R5: Every status read (address 0x00) starts exactly WAIT_CYC idle cycles after the preceding write or status read completes.
- R6: On the first status read whose bit 0 is 1, no further status read occurs. The sequencer writes the control address with only bit 4 set among bits 0 to 4 and other bits kept. It then pulses done for one cycle.
- R7: If POLLS (default 4) status reads all show bit 0 at 0, there is no further write. lock_err pulses for one cycle and done stays low.
- R8: busy stays high from the cycle after start through the done or error cycle and is low on the cycle after. A start that arrives while busy is high has no effect on the operation sequence, and no new run begins.
- R9: A valid held without ready keeps its address and data stable. The write and read ports are never valid in the same cycle.
- R10: During reset, busy, done, lock_err, wr_valid and rd_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a reprogramming run (one cycle) |
| mult_word | input | 32 | Multiplier register word, taken with start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: lock seen, output enabled |
| lock_err | output | 1 | One-cycle pulse: no lock within the poll budget |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | AW | Write address |
| wr_data | output | 32 | Write data |
| rd_valid | output | 1 | Read request |
| rd_ready | input | 1 | Read data valid, read accepted |
| rd_addr | output | AW | Read address |
| rd_data | input | 32 | Read data, sampled when rd_ready is high |

## Verification
The hardest case to reach is lock that appears only on the last allowed poll. It needs the PLL model's lock delay to fall between the third and fourth status samples. A directed run with ready held high fixes the poll times, and a lock delay placed between them hits this case. Random runs add stall cycles on both ports and lock delays that fall anywhere, including never. Each run's outcome is judged against the status values the model actually returned. Random runs also repeat start while the block is busy.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
    localparam int REG_W = 32;

    localparam int CTL_PWRDN_BIT = 0;
    localparam int CTL_OUTEN_BIT = 4;
    localparam logic [REG_W-1:0] CTL_CLR_MASK = 32'h0000_001F;
    localparam logic [REG_W-1:0] DIV_ONE_WORD = 32'h0030_2062;
    localparam int STS_LOCK_BIT = 0;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_CTRL,
        S_WR_PD,
        S_WR_MUL,
        S_WR_DIV,
        S_WR_PU,
        S_WAIT,
        S_RD_STAT,
        S_WR_EN,
        S_DONE,
        S_FAIL
    } seq_state_t;
endpackage

// File: rtl/pll_wait_timer.sv
module pll_wait_timer #(
    parameter int WAIT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(WAIT_CYC + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == TW'(WAIT_CYC - 1));

    // R5
    expire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !expired);
endmodule

// File: rtl/pll_poll_counter.sv
module pll_poll_counter #(
    parameter int POLLS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int PW = (POLLS > 1) ? $clog2(POLLS) : 1;

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == PW'(POLLS - 1));

    // R7
    no_inc_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> !inc);
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter int AW = 8,
    parameter logic [AW-1:0] STAT_ADDR = 8'h00,
    parameter logic [AW-1:0] CTRL_ADDR = 8'h04,
    parameter logic [AW-1:0] MUL_ADDR  = 8'h08,
    parameter logic [AW-1:0] DIV_ADDR  = 8'h0C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REG_W-1:0] mult_word,
    output logic             busy,
    output logic             done,
    output logic             lock_err,
    output logic             wr_valid,
    input  logic             wr_ready,
    output logic [AW-1:0]    wr_addr,
    output logic [REG_W-1:0] wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [AW-1:0]    rd_addr,
    input  logic [REG_W-1:0] rd_data,
    output logic             tmr_run,
    input  logic             tmr_expired,
    output logic             poll_clr,
    output logic             poll_inc,
    input  logic             poll_last
);
    seq_state_t state, nxt;
    logic [REG_W-1:0] ctrl_q, mult_q, ctrl_base;
    logic locked_rd;

    assign ctrl_base = ctrl_q & ~CTL_CLR_MASK;
    assign locked_rd = rd_data[STS_LOCK_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mult_q <= '0;
        end else begin
            if (state == S_IDLE && start)     mult_q <= mult_word;
            if (state == S_RD_CTRL && rd_ready) ctrl_q <= rd_data;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (start)       nxt = S_RD_CTRL;
            S_RD_CTRL: if (rd_ready)    nxt = S_WR_PD;
            S_WR_PD:   if (wr_ready)    nxt = S_WR_MUL;
            S_WR_MUL:  if (wr_ready)    nxt = S_WR_DIV;
            S_WR_DIV:  if (wr_ready)    nxt = S_WR_PU;
            S_WR_PU:   if (wr_ready)    nxt = S_WAIT;
            S_WAIT:    if (tmr_expired) nxt = S_RD_STAT;
            S_RD_STAT: if (rd_ready) begin
                if (locked_rd)      nxt = S_WR_EN;
                else if (poll_last) nxt = S_FAIL;
                else                nxt = S_WAIT;
            end
            S_WR_EN:   if (wr_ready)    nxt = S_DONE;
            S_DONE:    nxt = S_IDLE;
            S_FAIL:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state != S_IDLE);
        done     = 1'b0;
        lock_err = 1'b0;
        wr_valid = 1'b0;
        wr_addr  = CTRL_ADDR;
        wr_data  = '0;
        rd_valid = 1'b0;
        rd_addr  = CTRL_ADDR;
        tmr_run  = 1'b0;
        poll_clr = 1'b0;
        poll_inc = 1'b0;
        unique case (state)
            S_IDLE:    poll_clr = 1'b1;
            S_RD_CTRL: rd_valid = 1'b1;
            S_WR_PD: begin
                wr_valid = 1'b1;
                wr_data  = ctrl_base | (REG_W'(1) << CTL_PWRDN_BIT);
            end
            S_WR_MUL: begin
                wr_valid = 1'b1;
                wr_addr  = MUL_ADDR;
                wr_data  = mult_q;
            end
            S_WR_DIV: begin
                wr_valid = 1'b1;
                wr_addr  = DIV_ADDR;
                wr_data  = DIV_ONE_WORD;
            end
            S_WR_PU: begin
                wr_valid = 1'b1;
                wr_data  = ctrl_base;
            end
            S_WAIT:    tmr_run = 1'b1;
            S_RD_STAT: begin
                rd_valid = 1'b1;
                rd_addr  = STAT_ADDR;
                poll_inc = rd_ready && !locked_rd && !poll_last;
            end
            S_WR_EN: begin
                wr_valid = 1'b1;
                wr_data  = ctrl_base | (REG_W'(1) << CTL_OUTEN_BIT);
            end
            S_DONE:    done = 1'b1;
            S_FAIL:    lock_err = 1'b1;
            default:   ;
        endcase
    end

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && rd_valid && rd_addr == CTRL_ADDR));
    // R9
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
    // R9
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && rd_valid));
    // R8
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || lock_err) |=> !(busy || done || lock_err));
    // R7
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && lock_err));
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int WAIT_CYC = 1000,
    parameter int POLLS    = 4,
    parameter int AW       = 8,
    parameter logic [AW-1:0] STAT_ADDR = 8'h00,
    parameter logic [AW-1:0] CTRL_ADDR = 8'h04,
    parameter logic [AW-1:0] MUL_ADDR  = 8'h08,
    parameter logic [AW-1:0] DIV_ADDR  = 8'h0C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REG_W-1:0] mult_word,
    output logic             busy,
    output logic             done,
    output logic             lock_err,
    output logic             wr_valid,
    input  logic             wr_ready,
    output logic [AW-1:0]    wr_addr,
    output logic [REG_W-1:0] wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [AW-1:0]    rd_addr,
    input  logic [REG_W-1:0] rd_data
);
    logic tmr_run, tmr_expired, poll_clr, poll_inc, poll_last;

    pll_seq_fsm #(
        .AW(AW), .STAT_ADDR(STAT_ADDR), .CTRL_ADDR(CTRL_ADDR),
        .MUL_ADDR(MUL_ADDR), .DIV_ADDR(DIV_ADDR)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .mult_word(mult_word),
        .busy(busy), .done(done), .lock_err(lock_err),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
        .tmr_run(tmr_run), .tmr_expired(tmr_expired),
        .poll_clr(poll_clr), .poll_inc(poll_inc), .poll_last(poll_last)
    );

    pll_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .expired(tmr_expired)
    );

    pll_poll_counter #(.POLLS(POLLS)) u_poll (
        .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc), .last(poll_last)
    );
endmodule

// File: tb/sim_pll_reprog_seq.sv
module sim_pll_reprog_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WAITC = 16;
    localparam int NPOLL = 4;
    localparam logic [7:0] A_STAT = 8'h00, A_CTRL = 8'h04, A_MUL = 8'h08, A_DIV = 8'h0C;
    localparam int NEVER = 100000;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [31:0] mult_word = '0;
    logic busy, done, lock_err, wr_valid, wr_ready, rd_valid, rd_ready;
    logic [7:0] wr_addr, rd_addr;
    logic [31:0] wr_data, rd_data;

    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_reprog_seq #(.WAIT_CYC(WAITC), .POLLS(NPOLL)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mult_word(mult_word),
        .busy(busy), .done(done), .lock_err(lock_err),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // PLL register model
    logic [31:0] m_ctrl = '0, m_mul = '0, m_div = '0;
    bit powered = 0;
    int since = 0, lock_delay = 0;
    bit rand_ready = 0;

    function automatic logic [31:0] rdval(logic [7:0] a);
        if (a == A_CTRL) return m_ctrl;
        if (a == A_MUL)  return m_mul;
        if (a == A_DIV)  return m_div;
        if (a == A_STAT) return {31'b0, powered && (since >= lock_delay)};
        return 32'hDEAD_0000;
    endfunction

    assign rd_data = rdval(rd_addr);

    // operation log
    bit          op_wr [16];
    logic [7:0]  op_a  [16];
    logic [31:0] op_d  [16];
    int n_ops = 0;
    int idle_run = 0;
    bit prev_rd = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            wr_ready = 1'b0;
            rd_ready = 1'b0;
        end else begin
            if (powered && since < 1000000) since++;
            wr_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
            rd_ready = rand_ready ? (($urandom % 3) != 0) : 1'b1;
            // R5: idle gap before each status read
            if (rd_valid && !prev_rd && rd_addr == A_STAT)
                chk(idle_run == WAITC, "R5 wait gap", idle_run, WAITC);
            if (wr_valid || rd_valid) idle_run = 0;
            else if (busy) idle_run++;
            prev_rd = rd_valid;
            if (wr_valid && wr_ready) begin
                if (n_ops < 16) begin
                    op_wr[n_ops] = 1; op_a[n_ops] = wr_addr; op_d[n_ops] = wr_data;
                end
                n_ops++;
                if (wr_addr == A_CTRL) begin
                    m_ctrl = wr_data;
                    if (!wr_data[0]) begin powered = 1; since = 0; end
                    else powered = 0;
                end else if (wr_addr == A_MUL) m_mul = wr_data;
                else if (wr_addr == A_DIV) m_div = wr_data;
            end
            if (rd_valid && rd_ready) begin
                if (n_ops < 16) begin
                    op_wr[n_ops] = 0; op_a[n_ops] = rd_addr; op_d[n_ops] = rdval(rd_addr);
                end
                n_ops++;
            end
        end
    end

    task automatic trial(input logic [31:0] ctrl0, input logic [31:0] mult,
                         input int delay, input bit rr, input bit restart, input int exp_polls);
        int cyc;
        bit got_done, got_err, busy_gap;
        int first_lock, nstat, k;
        logic [31:0] base;
        @(negedge clk);
        m_ctrl = ctrl0; powered = 0; since = 0; lock_delay = delay;
        rand_ready = rr; n_ops = 0;
        mult_word = mult;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mult_word = $urandom;
        chk(busy === 1'b1, "R1 busy after start", busy, 1);
        chk(rd_valid === 1'b1 && rd_addr == A_CTRL, "R1 first op ctrl read", rd_addr, A_CTRL);
        cyc = 0; got_done = 0; got_err = 0; busy_gap = 0;
        while (!(done || lock_err) && cyc < 2000) begin
            if (!busy) busy_gap = 1;
            start = restart && (cyc == 7 || cyc == 40);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        got_done = done; got_err = lock_err;
        chk(!busy_gap && busy === 1'b1, "R8 busy held through run", busy, 1);
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && lock_err === 1'b0, "R8 busy low after end",
            {busy, done, lock_err}, 0);
        base = ctrl0 & ~32'h1F;
        chk(op_wr[0] == 0 && op_a[0] == A_CTRL, "R1 op0 ctrl read", op_a[0], A_CTRL);
        chk(op_wr[1] && op_a[1] == A_CTRL && op_d[1] == (base | 32'h1), "R2 power-down write",
            op_d[1], base | 32'h1);
        chk(op_wr[2] && op_a[2] == A_MUL && op_d[2] == mult, "R3 multiplier write", op_d[2], mult);
        chk(op_wr[3] && op_a[3] == A_DIV && op_d[3] == 32'h0030_2062, "R3 divider write",
            op_d[3], 32'h0030_2062);
        chk(op_wr[4] && op_a[4] == A_CTRL && op_d[4] == base, "R4 power-up write", op_d[4], base);
        first_lock = -1; nstat = 0;
        for (int i = 5; i < 16 && i < n_ops; i++) begin
            if (!op_wr[i] && op_a[i] == A_STAT) begin
                nstat++;
                if (first_lock < 0 && op_d[i][0]) first_lock = nstat;
            end
        end
        if (first_lock > 0) begin
            chk(nstat == first_lock, "R6 polling stops at lock", nstat, first_lock);
            k = 5 + nstat;
            chk(n_ops == k + 1 && op_wr[k] && op_a[k] == A_CTRL && op_d[k] == (base | 32'h10),
                "R6 enable write", op_d[k], base | 32'h10);
            chk(got_done && !got_err, "R6 done pulse", {got_done, got_err}, 2'b10);
        end else begin
            chk(nstat == NPOLL, "R7 poll budget", nstat, NPOLL);
            chk(n_ops == 5 + NPOLL, "R7 no enable write", n_ops, 5 + NPOLL);
            chk(got_err && !got_done, "R7 error pulse", {got_done, got_err}, 2'b01);
        end
        if (exp_polls > 0) chk(nstat == exp_polls, "R6 directed poll count", nstat, exp_polls);
        if (exp_polls < 0) chk(got_err, "R7 directed error", got_err, 1);
        // R8: no new run after a start seen while busy
        repeat (6) @(negedge clk);
        chk(busy === 1'b0 && n_ops == 5 + nstat + (first_lock > 0 ? 1 : 0),
            "R8 ignored start", n_ops, 5 + nstat + (first_lock > 0 ? 1 : 0));
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int dl;
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        // R10
        chk(busy === 0 && done === 0 && lock_err === 0 && wr_valid === 0 && rd_valid === 0,
            "R10 reset state", {busy, done, lock_err, wr_valid, rd_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        trial(32'hFFFF_FFFF, 32'h0001_2345, 0,     0, 0, 1);
        trial(32'hA5A5_5A5A, 32'h0000_4000, 25,    0, 0, 2);
        trial(32'h0000_001F, 32'h00C0_0003, 60,    0, 0, 4);
        trial(32'h1234_5678, 32'h0FFF_FFFF, NEVER, 0, 0, -1);
        trial(32'h0000_0000, 32'h0000_0001, NEVER, 0, 1, -1);
        for (int t = 0; t < 40; t++) begin
            dl = (($urandom % 4) == 0) ? NEVER : int'($urandom % 90);
            trial($urandom, $urandom, dl, 1, ($urandom % 2) == 1, 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule